// File: doc/BRIEF.md
# Card Address Window and Strobe Timer

This block drives the card side of one socket of a removable card bus bridge. A host access arrives as a request with a window index, a 20-bit offset inside that window's fixed 1 MB span, and a read/write flag. The block looks up the chosen window, forms a 26-bit card address by placing the window's 6-bit base above the offset, and presents the window's address-space code (attribute memory, common memory or I/O) beside it. It then runs the command strobe using that window's timing: a setup delay, a strobe of programmable length, an optional wait-extension point, and a recovery gap. It finishes with a one-cycle done pulse.

Each of the three windows has two 16-bit registers. These are written through a small write port and take effect only while the sequencer is idle. If the card holds wait for too long, the access is aborted and flagged as a timeout. A request to a window that does not exist, or to a window programmed with the reserved space code, is finished at once with an error and no strobe.

Top module: `card_win_ctrl`

## Requirements
- R1: `card_addr_o` equals the window's base (register 0 bits 5:0) placed above the 20-bit offset. It and `card_wr_o` are valid from the cycle after acceptance and stay unchanged until done.
- R2: `space_o` carries register 0 bits 7:6 of the selected window: 00 attribute memory, 01 common memory, 10 I/O.
- R3: The acceptance edge counts as cycle 0. The strobe first goes high in cycle 1+D, where D is register 0 bits 9:8.
- R4: The strobe stays high for L+1 consecutive cycles, where L is register 0 bits 14:10. This holds when register 1 bit 0 is 0, when wait is low at the sample point, or when the wait delay exceeds L.
- R5: When register 1 bit 0 is 1, `wait_i` is sampled in strobe cycle index W, where W is register 1 bits 2:1 and the first strobe cycle is index 0. If it is high there, the strobe is lengthened by one cycle for each following cycle, up to and including the first cycle that sees `wait_i` low.
- R6: `done_o` is a one-cycle pulse in the cycle R after the first non-strobe cycle, where R is register 1 bits 4:3. `ready_o` is high again in the next cycle.
- R7: If `wait_i` is still high on the 1023rd extension cycle, the strobe ends after that cycle. `done_o` then pulses together with `tout_o` in the next cycle, with no recovery gap. Releasing wait on the 1023rd extension cycle completes normally.
- R8: A window programmed with space code 11 completes in cycle 1 with `done_o` and `err_o` high, and the strobe is never asserted.
- R9: A window index of 3 is rejected in the same way as R8.
- R10: A request is accepted only in a cycle where `ready_o` is high. Requests made during an access are ignored.
- R11: A configuration write (`cfg_sel_i` 0 selects register 0, 1 selects register 1) updates the window only when `ready_o` is high. A write while busy is dropped.
- R12: After reset `ready_o` is high and `strobe_o`, `done_o`, `err_o` and `tout_o` are low.
- R13: Each window keeps its own registers, so consecutive accesses to different windows use their own timing and base without reprogramming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Window register write strobe |
| cfg_win_i | input | 2 | Window index for the write |
| cfg_sel_i | input | 1 | 0 selects register 0, 1 selects register 1 |
| cfg_data_i | input | 16 | Write data |
| req_i | input | 1 | Access request |
| req_win_i | input | 2 | Window index of the request |
| req_off_i | input | 20 | Offset inside the 1 MB window |
| req_wr_i | input | 1 | 1 for a write access |
| wait_i | input | 1 | Card wait, high to hold the strobe |
| ready_o | output | 1 | Sequencer idle, request can be taken |
| card_addr_o | output | 26 | Card address |
| space_o | output | 2 | Card address space code |
| card_wr_o | output | 1 | Direction of the current access |
| strobe_o | output | 1 | Command strobe |
| done_o | output | 1 | Access finished (one cycle) |
| err_o | output | 1 | Access rejected, valid with done |
| tout_o | output | 1 | Access aborted by wait timeout, valid with done |

## Verification
Every result is tied to a cycle number that counts from the acceptance edge. The address, space and direction are due in cycle 1. The strobe rises in cycle 1+D and lasts L+1 cycles plus any wait extension. Done follows R cycles after the strobe falls, or comes in cycle 1 for a rejected access. The bench drives inputs and samples outputs on falling edges, counting cycles from acceptance. It feeds `wait_i` as a function of the strobe cycle index it has itself observed, and compares the measured rise cycle, strobe length and done cycle with values it derives from its own copy of the programmed fields. The extension limit is probed on both sides, with release on exactly the 1023rd extension cycle and one cycle later.

// File: rtl/card_win_pkg.sv
`timescale 1ns/1ps
package card_win_pkg;
  localparam int unsigned BASE_W = 6;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned DLY_W  = 2;

  typedef enum logic [1:0] {
    SP_ATTR = 2'b00,
    SP_COMM = 2'b01,
    SP_IO   = 2'b10,
    SP_RSVD = 2'b11
  } space_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [DLY_W-1:0] dly;
    logic [DLY_W-1:0] rec;
    logic [DLY_W-1:0] wdly;
    logic             wreq;
  } tim_t;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    space_e            space;
    tim_t              tim;
  } win_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_REC, ST_DONE
  } seq_state_e;

  // register 0: [14:10] len, [9:8] dly, [7:6] space, [5:0] base
  function automatic win_cfg_t put_reg0(win_cfg_t c, logic [14:0] d);
    win_cfg_t r = c;
    r.tim.len = d[14:10];
    r.tim.dly = d[9:8];
    r.space   = space_e'(d[7:6]);
    r.base    = d[5:0];
    return r;
  endfunction

  // register 1: [4:3] rec, [2:1] wdly, [0] wreq
  function automatic win_cfg_t put_reg1(win_cfg_t c, logic [4:0] d);
    win_cfg_t r = c;
    r.tim.rec  = d[4:3];
    r.tim.wdly = d[2:1];
    r.tim.wreq = d[0];
    return r;
  endfunction
endpackage

// File: rtl/card_win_regs.sv
`timescale 1ns/1ps
module card_win_regs
  import card_win_pkg::*;
#(
  parameter int unsigned N_WIN = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             sel_i,
  input  logic [15:0]      data_i,
  output win_cfg_t         cfg_o [N_WIN]
);
  logic unused_rsvd;
  assign unused_rsvd = data_i[15];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    win_cfg_t cfg_q;
    logic     hit;
    assign hit = we_i && idle_i && (win_i == IDX_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (hit) begin
        if (!sel_i) cfg_q <= put_reg0(cfg_q, data_i[14:0]);
        else        cfg_q <= put_reg1(cfg_q, data_i[4:0]);
      end
    end
    assign cfg_o[w] = cfg_q;
  end
endmodule

// File: rtl/card_win_decode.sv
`timescale 1ns/1ps
module card_win_decode
  import card_win_pkg::*;
#(
  parameter int unsigned N_WIN = 3,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned OFF_W = 20,
  localparam int unsigned ADDR_W = BASE_W + OFF_W
) (
  input  win_cfg_t          cfg_i [N_WIN],
  input  logic [IDX_W-1:0]  win_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o,
  output space_e            space_o,
  output tim_t              tim_o,
  output logic              bad_o
);
  win_cfg_t sel;
  logic     in_range;

  always_comb begin
    sel = '0;
    for (int w = 0; w < N_WIN; w++) begin
      if (win_i == IDX_W'(w)) sel = cfg_i[w];
    end
  end

  assign in_range = {1'b0, win_i} < (IDX_W+1)'(N_WIN);
  assign addr_o   = {sel.base, off_i};
  assign space_o  = sel.space;
  assign tim_o    = sel.tim;
  assign bad_o    = !in_range || (sel.space == SP_RSVD);
endmodule

// File: rtl/card_strobe_seq.sv
`timescale 1ns/1ps
module card_strobe_seq
  import card_win_pkg::*;
#(
  parameter int unsigned TMO_LIMIT = 1023,
  localparam int unsigned TMO_W = $clog2(TMO_LIMIT + 1),
  localparam int unsigned CNT_W = LEN_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bad_i,
  input  tim_t tim_i,
  input  logic wait_i,
  output logic idle_o,
  output logic strobe_o,
  output logic done_o,
  output logic err_o,
  output logic tout_o
);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_LIMIT - 1);

  seq_state_e       state_q;
  tim_t             tim_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             err_q, tout_q;

  logic [CNT_W-1:0] len_x, dly_last, rec_last, wdly_x;
  logic             wait_hit, strobe_end;
  seq_state_e       after_strobe;

  assign len_x        = tim_q.len;
  assign dly_last     = CNT_W'(tim_q.dly) - CNT_W'(1);
  assign rec_last     = CNT_W'(tim_q.rec) - CNT_W'(1);
  assign wdly_x       = CNT_W'(tim_q.wdly);
  assign wait_hit     = tim_q.wreq && (cnt_q == wdly_x) && wait_i;
  assign strobe_end   = (cnt_q == len_x);
  assign after_strobe = (tim_q.rec != '0) ? ST_REC : ST_DONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tim_q   <= '0;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      err_q   <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          tim_q  <= tim_i;
          cnt_q  <= '0;
          tcnt_q <= '0;
          err_q  <= bad_i;
          tout_q <= 1'b0;
          if (bad_i)                 state_q <= ST_DONE;
          else if (tim_i.dly != '0)  state_q <= ST_SETUP;
          else                       state_q <= ST_STROBE;
        end
        ST_SETUP: begin
          if (cnt_q == dly_last) begin
            cnt_q   <= '0;
            state_q <= ST_STROBE;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_STROBE: begin
          if (wait_hit) begin
            tcnt_q  <= '0;
            state_q <= ST_HOLD;
          end else if (strobe_end) begin
            cnt_q   <= '0;
            state_q <= after_strobe;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_HOLD: begin
          if (wait_i) begin
            if (tcnt_q == TMO_LAST) begin
              tout_q  <= 1'b1;
              state_q <= ST_DONE;
            end else tcnt_q <= tcnt_q + TMO_W'(1);
          end else if (strobe_end) begin
            cnt_q   <= '0;
            state_q <= after_strobe;
          end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            state_q <= ST_STROBE;
          end
        end
        ST_REC: begin
          if (cnt_q == rec_last) state_q <= ST_DONE;
          else                   cnt_q   <= cnt_q + CNT_W'(1);
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign strobe_o = (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign done_o   = (state_q == ST_DONE);
  assign err_o    = done_o && err_q;
  assign tout_o   = done_o && tout_q;
endmodule

// File: rtl/card_win_ctrl.sv
`timescale 1ns/1ps
module card_win_ctrl
  import card_win_pkg::*;
#(
  parameter int unsigned N_WIN     = 3,
  parameter int unsigned OFF_W     = 20,
  parameter int unsigned TMO_LIMIT = 1023,
  localparam int unsigned IDX_W    = $clog2(N_WIN + 1),
  localparam int unsigned ADDR_W   = BASE_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_win_i,
  input  logic              cfg_sel_i,
  input  logic [15:0]       cfg_data_i,
  input  logic              req_i,
  input  logic [IDX_W-1:0]  req_win_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic              req_wr_i,
  input  logic              wait_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] card_addr_o,
  output logic [1:0]        space_o,
  output logic              card_wr_o,
  output logic              strobe_o,
  output logic              done_o,
  output logic              err_o,
  output logic              tout_o
);
  win_cfg_t          cfg [N_WIN];
  logic [ADDR_W-1:0] dec_addr;
  space_e            dec_space;
  tim_t              dec_tim;
  logic              dec_bad, idle, accept;
  logic [ADDR_W-1:0] addr_q;
  space_e            space_q;
  logic              wr_q;

  card_win_regs #(.N_WIN(N_WIN), .IDX_W(IDX_W)) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .idle_i (idle),
    .we_i (cfg_we_i), .win_i (cfg_win_i), .sel_i (cfg_sel_i),
    .data_i (cfg_data_i), .cfg_o (cfg)
  );

  card_win_decode #(.N_WIN(N_WIN), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dec (
    .cfg_i (cfg), .win_i (req_win_i), .off_i (req_off_i),
    .addr_o (dec_addr), .space_o (dec_space), .tim_o (dec_tim), .bad_o (dec_bad)
  );

  assign accept = req_i && idle;

  card_strobe_seq #(.TMO_LIMIT(TMO_LIMIT)) u_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (accept), .bad_i (dec_bad),
    .tim_i (dec_tim), .wait_i (wait_i), .idle_o (idle), .strobe_o (strobe_o),
    .done_o (done_o), .err_o (err_o), .tout_o (tout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      space_q <= SP_ATTR;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= dec_addr;
      space_q <= dec_space;
      wr_q    <= req_wr_i;
    end
  end

  assign ready_o     = idle;
  assign card_addr_o = addr_q;
  assign space_o     = space_q;
  assign card_wr_o   = wr_q;
endmodule

// File: rtl/card_win_ctrl_chk.sv
`timescale 1ns/1ps
module card_win_ctrl_chk #(
  parameter int unsigned ADDR_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              wait_i,
  input logic              ready_o,
  input logic [ADDR_W-1:0] card_addr_o,
  input logic              strobe_o,
  input logic              done_o,
  input logic              err_o,
  input logic              tout_o
);
  // R10
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !ready_o);

  // R8
  err_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !strobe_o && $past(ready_o && req_i)));

  // R7
  tout_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |-> (done_o && $past(strobe_o) && $past(wait_i)));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (ready_o && !done_o));

  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && $past(!ready_o)) |-> $stable(card_addr_o));
endmodule

bind card_win_ctrl card_win_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .wait_i (wait_i),
  .ready_o (ready_o), .card_addr_o (card_addr_o), .strobe_o (strobe_o),
  .done_o (done_o), .err_o (err_o), .tout_o (tout_o)
);

// File: tb/card_win_ctrl_test.sv
`timescale 1ns/1ps
module card_win_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_win_i = '0;
  logic        cfg_sel_i = 1'b0;
  logic [15:0] cfg_data_i = '0;
  logic        req_i = 1'b0;
  logic [1:0]  req_win_i = '0;
  logic [19:0] req_off_i = '0;
  logic        req_wr_i = 1'b0;
  logic        wait_i = 1'b0;
  logic        ready_o, card_wr_o, strobe_o, done_o, err_o, tout_o;
  logic [25:0] card_addr_o;
  logic [1:0]  space_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] sh0 [4];
  logic [15:0] sh1 [4];
  int obs_addr, obs_scnt, exp_scnt_g;

  always #2.5 clk_i = ~clk_i;

  card_win_ctrl uut (.*);

  typedef struct packed {
    logic [1:0]  win;
    logic [19:0] off;
    logic        wr;
    logic [15:0] r0;
    logic [15:0] r1;
    logic [11:0] wlen;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 20'h12345, 1'b0, 16'h0D45, 16'h0010, 12'd0},
    '{2'd1, 20'hFFFFF, 1'b1, 16'h003F, 16'h0000, 12'd0},
    '{2'd2, 20'h00000, 1'b0, 16'h13A0, 16'h001D, 12'd6},
    '{2'd0, 20'hABCDE, 1'b0, 16'h0841, 16'h0008, 12'd8},
    '{2'd1, 20'h00010, 1'b1, 16'h0610, 16'h0007, 12'd10},
    '{2'd2, 20'h00100, 1'b0, 16'h00C7, 16'h0000, 12'd0},
    '{2'd3, 20'h00200, 1'b0, 16'h0041, 16'h0000, 12'd0},
    '{2'd0, 20'h00ABC, 1'b1, 16'h0082, 16'h0009, 12'd1023},
    '{2'd0, 20'h00ABD, 1'b0, 16'h0082, 16'h0009, 12'd1024},
    '{2'd1, 20'h54321, 1'b0, 16'h096A, 16'h0003, 12'd1},
    '{2'd2, 20'h3C3C3, 1'b1, 16'h7F7E, 16'h0018, 12'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input int win, input bit sel, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_win_i = 2'(win); cfg_sel_i = sel; cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (win < 3) begin
      if (!sel) sh0[win] = d; else sh1[win] = d;
    end
  endtask

  task automatic do_vec(input int win, input int off, input bit wr, input int wl);
    int len, dly, sp, base, rec, wdly, wreq, h;
    int e_rise, e_scnt, e_done, e_err, e_tout;
    int rise, scnt, done_n, o_err, o_tout, o_addr, o_sp, o_wr;
    bit bad;
    len  = (win < 3) ? int'(sh0[win][14:10]) : 0;
    dly  = (win < 3) ? int'(sh0[win][9:8])   : 0;
    sp   = (win < 3) ? int'(sh0[win][7:6])   : 0;
    base = (win < 3) ? int'(sh0[win][5:0])   : 0;
    rec  = (win < 3) ? int'(sh1[win][4:3])   : 0;
    wdly = (win < 3) ? int'(sh1[win][2:1])   : 0;
    wreq = (win < 3) ? int'(sh1[win][0])     : 0;
    bad  = (win >= 3) || (sp == 3);
    e_tout = 0;
    if (bad) begin
      e_rise = -1; e_scnt = 0; e_done = 1; e_err = 1;
    end else begin
      e_err = 0;
      e_rise = 1 + dly;
      h = (wreq == 1 && wdly <= len && wl > wdly) ? wl - wdly : 0;
      if (h > 1023) begin
        e_tout = 1; e_scnt = wdly + 1 + 1023; e_done = e_rise + e_scnt;
      end else begin
        e_scnt = len + 1 + h; e_done = e_rise + e_scnt + rec;
      end
    end
    @(negedge clk_i);
    req_i = 1'b1; req_win_i = 2'(win); req_off_i = 20'(off); req_wr_i = wr;
    @(negedge clk_i);
    req_i = 1'b0;
    rise = -1; scnt = 0; done_n = -1; o_err = 0; o_tout = 0;
    o_addr = 0; o_sp = 0; o_wr = 0;
    for (int n = 1; n <= 3000; n++) begin
      if (n == 1) begin
        o_addr = int'(card_addr_o); o_sp = int'(space_o); o_wr = int'(card_wr_o);
      end
      if (strobe_o) begin
        if (rise < 0) rise = n;
        wait_i = (scnt < wl);
        scnt++;
      end else wait_i = 1'b0;
      if (done_o) begin
        done_n = n; o_err = int'(err_o); o_tout = int'(tout_o);
        break;
      end
      @(negedge clk_i);
    end
    wait_i = 1'b0;
    obs_addr = o_addr; obs_scnt = scnt; exp_scnt_g = e_scnt;
    chk(win >= 3 ? "R9 error flag" : "R8 error flag", o_err, e_err);
    chk(bad ? "R8 no strobe on reject" : (wreq == 1 ? "R5 strobe length" : "R4 strobe length"),
        scnt, e_scnt);
    chk(bad ? "R8 done cycle" : "R6 done cycle", done_n, e_done);
    chk("R7 timeout flag", o_tout, e_tout);
    if (!bad) begin
      chk("R1 card address", o_addr, (base << 20) | off);
      chk("R1 direction", o_wr, int'(wr));
      chk("R2 space select", o_sp, sp);
      chk("R3 strobe rise cycle", rise, e_rise);
    end
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int sc;
    for (int i = 0; i < 4; i++) begin sh0[i] = '0; sh1[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R12
    chk("R12 ready after reset", int'(ready_o), 1);
    chk("R12 strobe after reset", int'(strobe_o), 0);
    chk("R12 done after reset", int'(done_o | err_o | tout_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      wr_cfg(int'(VEC[i].win), 1'b0, VEC[i].r0);
      wr_cfg(int'(VEC[i].win), 1'b1, VEC[i].r1);
      do_vec(int'(VEC[i].win), int'(VEC[i].off), VEC[i].wr, int'(VEC[i].wlen));
    end

    // R10: requests during an access are dropped
    wr_cfg(0, 1'b0, 16'h1449);
    wr_cfg(0, 1'b1, 16'h0000);
    @(negedge clk_i);
    req_i = 1'b1; req_win_i = 2'd0; req_off_i = 20'h00001; req_wr_i = 1'b0;
    @(negedge clk_i);
    chk("R10 busy after accept", int'(ready_o), 0);
    req_win_i = 2'd1; req_off_i = 20'h55555;
    sc = 0;
    for (int n = 1; n <= 20; n++) begin
      if (strobe_o) sc++;
      if (done_o) break;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    chk("R10 first access strobe length", sc, 6);
    sc = 0;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk_i);
      if (strobe_o || !ready_o) sc++;
    end
    chk("R10 no second access", sc, 0);

    // R11: write while busy is dropped
    @(negedge clk_i);
    req_i = 1'b1; req_win_i = 2'd0; req_off_i = 20'h00002;
    @(negedge clk_i);
    req_i = 1'b0;
    cfg_we_i = 1'b1; cfg_win_i = 2'd0; cfg_sel_i = 1'b0; cfg_data_i = 16'h1451;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    for (int n = 0; n < 20; n++) begin
      if (done_o) break;
      @(negedge clk_i);
    end
    do_vec(0, 32'h00777, 1'b0, 0);
    chk("R11 busy write ignored", obs_addr, (9 << 20) | 32'h00777);

    // R13: windows 1 and 2 keep their own settings
    do_vec(1, 32'h00042, 1'b1, 0);
    chk("R13 window 1 timing", obs_scnt, 3);
    do_vec(2, 32'h00043, 1'b0, 0);
    chk("R13 window 2 timing", obs_scnt, 32);
    chk("R13 window 2 base", obs_addr, (32'h3E << 20) | 32'h00043);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule